// File: doc/BRIEF.md
# Cascadable Presettable Up/Down Counter

This block is a synchronous binary counter whose width is set by a parameter (four bits by default). The count changes only on the rising clock edge. A synchronous reset clears it. An active-low load input copies a parallel data word into it. It counts when two active-low enables are both asserted, and otherwise it holds. A direction input chooses whether it increments or decrements. Counting is modular, so the count wraps at both ends of its range.

The block has an active-low terminal-count output for building wider counters. This output is a combinational decode of the present count, the direction input and the trickle enable. It goes low at the last state in the current direction: all ones when counting up, zero when counting down. The parallel enable has no effect on it. A wider counter is built by feeding one stage's terminal count into the count enables of the next stage. The next stage then advances exactly on the clock edge at which the lower stage wraps.

Top module: `updn_cascade_ctr`

## Requirements
- R1: While `rst` is high at a rising edge, the count becomes 0 on that edge. This takes priority over every other input.
- R2: When `load_n` is low (and `rst` is low) at a rising edge, `q` takes the value of `din` on that edge.
- R3: A load ignores `cen_par_n`, `cen_trk_n` and `up`. For example, a load of 8'hFF with both enables low and `up`=0 gives 8'hFF, not a decrement.
- R4: With `rst` low and `load_n` high, if either `cen_par_n` or `cen_trk_n` is high at the edge, `q` keeps its value.
- R5: With `rst` low, `load_n` high and both enables low, `up`=1 adds one to `q` and `up`=0 subtracts one from `q` at the edge.
- R6: `tc_n` is low exactly when `cen_trk_n` is low and either `up`=1 with `q` all ones, or `up`=0 with `q`=0. Otherwise `tc_n` is high. It follows these inputs combinationally and does not depend on `cen_par_n`.
- R7: Counting is modulo 2^W: all ones plus one gives 0, and 0 minus one gives all ones.
- R8: Two stages form a counter of twice the width when the low stage's `tc_n` drives both enables of the high stage and both stages share `up`, `load_n` and `rst`. The combined count then increments and decrements as a single binary number, including the wraps at 255 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear |
| load_n | input | 1 | Active-low parallel load |
| cen_par_n | input | 1 | Active-low count enable (does not gate `tc_n`) |
| cen_trk_n | input | 1 | Active-low count enable that also gates `tc_n` |
| up | input | 1 | Direction: 1 increments, 0 decrements |
| din | input | W | Parallel load data |
| q | output | W | Present count |
| tc_n | output | 1 | Active-low terminal count |

## Verification
The checker tests the single-stage rules on every cycle: clearing, loading, holding, stepping in either direction with wrap, and the exact terminal-count decode. Whether a chain of stages behaves as one wider counter is a system property. Only the bench scenarios show it, because the bench compares the two-stage count against an 8-bit reference through carries, borrows and wraps at both ends. The bench scenarios also show that load wins over enables set for counting, and that the terminal count ignores the parallel enable.

// File: rtl/updn_ctr_pkg.sv
package updn_ctr_pkg;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_INC  = 2'd2,
        OP_DEC  = 2'd3
    } ctr_op_e;

    typedef struct packed {
        logic load_n;
        logic cen_par_n;
        logic cen_trk_n;
        logic up;
    } ctr_ctl_t;

    // Load beats counting; counting needs both active-low enables.
    function automatic ctr_op_e pick_op(input ctr_ctl_t c);
        if (!c.load_n)
            return OP_LOAD;
        else if (c.cen_par_n || c.cen_trk_n)
            return OP_HOLD;
        else if (c.up)
            return OP_INC;
        else
            return OP_DEC;
    endfunction

endpackage

// File: rtl/updn_ctr_mode.sv
module updn_ctr_mode
    import updn_ctr_pkg::*;
(
    input  ctr_ctl_t ctl,
    output ctr_op_e  op
);
    always_comb op = pick_op(ctl);
endmodule

// File: rtl/updn_ctr_next.sv
module updn_ctr_next
    import updn_ctr_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] din,
    input  ctr_op_e      op,
    output logic [W-1:0] nxt
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    always_comb begin
        unique case (op)
            OP_LOAD: nxt = din;
            OP_INC:  nxt = cur + ONE;   // wraps modulo 2^W
            OP_DEC:  nxt = cur - ONE;
            default: nxt = cur;
        endcase
    end
endmodule

// File: rtl/updn_ctr_tc.sv
module updn_ctr_tc #(
    parameter int W = 4
) (
    input  logic [W-1:0] cur,
    input  logic         up,
    input  logic         cen_trk_n,
    output logic         tc_n
);
    logic at_top;
    logic at_bottom;

    always_comb begin
        at_top    = &cur;
        at_bottom = ~|cur;
        tc_n      = ~(~cen_trk_n & (up ? at_top : at_bottom));
    end
endmodule

// File: rtl/updn_cascade_ctr.sv
module updn_cascade_ctr
    import updn_ctr_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_n,
    input  logic         cen_par_n,
    input  logic         cen_trk_n,
    input  logic         up,
    input  logic [W-1:0] din,
    output logic [W-1:0] q,
    output logic         tc_n
);
    ctr_ctl_t     ctl;
    ctr_op_e      op;
    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_d;

    assign ctl = '{load_n: load_n, cen_par_n: cen_par_n,
                   cen_trk_n: cen_trk_n, up: up};

    updn_ctr_mode u_mode (
        .ctl (ctl),
        .op  (op)
    );

    updn_ctr_next #(.W(W)) u_next (
        .cur (cnt_q),
        .din (din),
        .op  (op),
        .nxt (cnt_d)
    );

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    updn_ctr_tc #(.W(W)) u_tc (
        .cur       (cnt_q),
        .up        (up),
        .cen_trk_n (cen_trk_n),
        .tc_n      (tc_n)
    );

    assign q = cnt_q;
endmodule

// File: rtl/updn_cascade_ctr_chk.sv
module updn_cascade_ctr_chk #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         rst,
    input logic         load_n,
    input logic         cen_par_n,
    input logic         cen_trk_n,
    input logic         up,
    input logic [W-1:0] din,
    input logic [W-1:0] q,
    input logic         tc_n
);
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] TOPV = {W{1'b1}};

    AST_RST_CLEARS: assert property (@(posedge clk)
        rst |=> q == '0);  // R1

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        !load_n |=> q == $past(din));  // R2

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (load_n && (cen_par_n || cen_trk_n)) |=> $stable(q));  // R4

    AST_STEP_UP: assert property (@(posedge clk) disable iff (rst)
        (load_n && !cen_par_n && !cen_trk_n && up) |=> q == $past(q) + ONE);  // R5

    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
        (load_n && !cen_par_n && !cen_trk_n && !up) |=> q == $past(q) - ONE);  // R5

    AST_WRAP_TOP: assert property (@(posedge clk) disable iff (rst)
        (load_n && !cen_par_n && !cen_trk_n && up && q == TOPV) |=> q == '0);  // R7

    AST_WRAP_BOTTOM: assert property (@(posedge clk) disable iff (rst)
        (load_n && !cen_par_n && !cen_trk_n && !up && q == '0) |=> q == TOPV);  // R7

    AST_TC_ARMED: assert property (@(posedge clk) disable iff (rst)
        (!cen_trk_n && ((up && q == TOPV) || (!up && q == '0))) |-> !tc_n);  // R6

    AST_TC_IDLE: assert property (@(posedge clk) disable iff (rst)
        (cen_trk_n || (up && q != TOPV) || (!up && q != '0)) |-> tc_n);  // R6
endmodule

bind updn_cascade_ctr updn_cascade_ctr_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .load_n    (load_n),
    .cen_par_n (cen_par_n),
    .cen_trk_n (cen_trk_n),
    .up        (up),
    .din       (din),
    .q         (q),
    .tc_n      (tc_n)
);

// File: tb/updn_cascade_ctr_test.sv
module updn_cascade_ctr_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       load_n = 1'b1;
    logic       cen_par_n = 1'b1;
    logic       cen_trk_n = 1'b1;
    logic       up = 1'b1;
    logic [7:0] din = 8'h00;
    logic [3:0] q_lo, q_hi;
    logic       tc_lo_n, tc_hi_n;
    logic [7:0] q8;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    updn_cascade_ctr #(.W(4)) uut (
        .clk(clk), .rst(rst), .load_n(load_n), .cen_par_n(cen_par_n),
        .cen_trk_n(cen_trk_n), .up(up), .din(din[3:0]), .q(q_lo), .tc_n(tc_lo_n)
    );

    updn_cascade_ctr #(.W(4)) u_hi (
        .clk(clk), .rst(rst), .load_n(load_n), .cen_par_n(tc_lo_n),
        .cen_trk_n(tc_lo_n), .up(up), .din(din[7:4]), .q(q_hi), .tc_n(tc_hi_n)
    );

    assign q8 = {q_hi, q_lo};

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // rst, load_n, cen_par_n, cen_trk_n, up, din, expected count after edge
    typedef struct packed {
        logic       r;
        logic       ld;
        logic       cp;
        logic       ct;
        logic       u;
        logic [7:0] d;
        logic [7:0] e;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h5A, 8'h00},  // R1 clear
        '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h0E, 8'h0E},  // R2 load
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 8'h0F},  // R5 up
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 8'h10},  // R8 carry
        '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 8'h10},  // R4 hold par
        '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 8'h10},  // R4 hold trk
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h0F},  // R8 borrow
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h0E},  // R5 down
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 8'hFF},  // R3 load wins
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00},  // R7 wrap top
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'hFF},  // R7 wrap bottom
        '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h77, 8'h00},  // R1 over load
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'hFF}   // R7 down from 0
    };

    task automatic step;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] ref8;
        @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            rst = VECS[i].r; load_n = VECS[i].ld; cen_par_n = VECS[i].cp;
            cen_trk_n = VECS[i].ct; up = VECS[i].u; din = VECS[i].d;
            step();
            check($sformatf("vector %0d R1/R2/R3/R4/R5/R7/R8", i), q8, VECS[i].e);
        end
        rst = 1'b0;

        // R6: terminal count decode on the low stage
        load_n = 1'b0; din = 8'h0F; step(); load_n = 1'b1;
        up = 1'b1; cen_par_n = 1'b1; cen_trk_n = 1'b0; #1;
        check("R6 tc low at top, par enable high", tc_lo_n, 0);
        cen_trk_n = 1'b1; #1;
        check("R6 tc high with trickle off", tc_lo_n, 1);
        cen_trk_n = 1'b0; up = 1'b0; #1;
        check("R6 tc high at top counting down", tc_lo_n, 1);
        load_n = 1'b0; din = 8'h30; step(); load_n = 1'b1; #1;
        check("R6 tc low at zero counting down", tc_lo_n, 0);
        cen_par_n = 1'b0; #1;
        check("R6 tc unaffected by par enable", tc_lo_n, 0);
        up = 1'b1; #1;
        check("R6 tc high at zero counting up", tc_lo_n, 1);
        cen_par_n = 1'b1;
        step();
        check("R4 hold with par enable high", q8, 8'h30);

        // R8/R7: long runs against an 8-bit reference
        load_n = 1'b0; din = 8'hF0; step(); load_n = 1'b1;
        ref8 = 8'hF0;
        cen_par_n = 1'b0; cen_trk_n = 1'b0; up = 1'b1;
        for (int k = 0; k < 300; k++) begin
            step(); ref8 = ref8 + 8'd1;
            if (q8 !== ref8) check("R8 chained up count", q8, ref8);
        end
        check("R8 chained up final", q8, ref8);
        up = 1'b0;
        for (int k = 0; k < 300; k++) begin
            step(); ref8 = ref8 - 8'd1;
            if (q8 !== ref8) check("R8 chained down count", q8, ref8);
        end
        check("R8 chained down final", q8, ref8);
        #1;
        check("R8 high tc idle mid-range", tc_hi_n, (ref8 == 8'h00) ? 0 : 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule